// File: doc/BRIEF.md
# Oversampled Serial Receiver with Three-Entry Status Queue

This block turns an asynchronous serial line into bytes. It samples the line on a 16x enable that comes from outside the block. Each finished character goes into a three-entry queue, together with its own framing, parity and break flags. The entry at the head of the queue is always visible on the output pins. A read strobe removes that entry.

When the queue is full, one more finished character can still wait in a holding slot. If another character completes while the queue is full and the holding slot is occupied, the block sets a sticky overrun flag. A break is a line held low for a whole character. It fills exactly one queue entry, and reception then stays blocked until the line has been idle again for half a bit. Separate strobes switch the receiver on and off, clear the overrun flag and clear the break-change flag.

Top module: `uart_rx_stat`

## Requirements
- R1: A low level seen on a tick is sampled again 8 ticks later. If the line is high by then, nothing is received and the receiver goes back to looking for a start bit.
- R2: Data bits are sampled every 16 ticks after the start check, least significant bit first. The head entry shows the data on `rx_data` and its flags on `rx_fe`, `rx_pe` and `rx_brk`.
- R3: When `par_en` is 1, one parity bit follows the data. `rx_pe` is 1 when the XOR of the data bits and the parity bit differs from `par_odd` (0 selects even parity, 1 selects odd). When `par_en` is 0, `rx_pe` is 0.
- R4: `rx_fe` is 1 when the line is low at the middle of the stop bit.
- R5: The queue holds 3 entries. `rdy` is 1 while at least one entry is queued. It falls only after a read that empties the queue.
- R6: `full` is 1 while all 3 entries are occupied. A read while a character is waiting in the holding slot moves that character into the queue, so `full` stays 1.
- R7: A character that completes while the queue is full and the holding slot is occupied replaces the held character, which is discarded, and sets `overrun`. `overrun` stays 1 until `cmd_clr_err`.
- R8: A break is all data bits 0, a parity bit of 0 if parity is enabled, and the stop bit low. A break queues one entry with `rx_brk`=1, `rx_fe`=1, `rx_pe`=0 and data 0. No further entries are queued until the line has been high for 8 consecutive ticks.
- R9: `brk_chg` is set when a break is detected and again when the break ends (8 high ticks). It stays set until `cmd_clr_brk`.
- R10: `cmd_rx_off` stops reception at once and drops any partial character. It leaves the queue and the flags untouched, and characters sent while the receiver is off are not received. `cmd_rx_on` restarts the search for a start bit.
- R11: After reset the receiver is off, the queue is empty, and `rdy`, `full`, `overrun` and `brk_chg` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, high when idle |
| par_en | input | 1 | A parity bit follows the data |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cmd_rx_on | input | 1 | Strobe: enable the receiver |
| cmd_rx_off | input | 1 | Strobe: disable the receiver |
| cmd_clr_err | input | 1 | Strobe: clear overrun |
| cmd_clr_brk | input | 1 | Strobe: clear break change |
| rd | input | 1 | Strobe: remove the head entry |
| rx_data | output | DATA_W | Head entry data |
| rx_fe | output | 1 | Head entry framing error |
| rx_pe | output | 1 | Head entry parity error |
| rx_brk | output | 1 | Head entry is a break |
| rdy | output | 1 | Queue not empty |
| full | output | 1 | Queue holds 3 entries |
| overrun | output | 1 | A held character was lost |
| brk_chg | output | 1 | A break started or ended |

## Verification
Some relations between the flags are checked by assertions on every cycle. Sticky `overrun` and `brk_chg` fall only on their clear strobes. `overrun` rises only while the queue is full, and `rdy` falls only after a read. A break entry at the head always carries zero data and a framing error. The other behaviour can only be shown by the bench's scenarios. These cover glitch rejection, bit order and parity sense, and which character is lost on overrun. They also cover the holding slot keeping `full` up, the half-bit idle needed to end a break, and losing a partial character on disable.

// File: rtl/uart_rx_stat.sv
`timescale 1ns/1ps
module uart_rx_stat #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              cmd_rx_on,
  input  logic              cmd_rx_off,
  input  logic              cmd_clr_err,
  input  logic              cmd_clr_brk,
  input  logic              rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_fe,
  output logic              rx_pe,
  output logic              rx_brk,
  output logic              rdy,
  output logic              full,
  output logic              overrun,
  output logic              brk_chg
);
  localparam int EW = DATA_W + 3;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

  st_t              st;
  logic             rx_on, pbit, hold_v, hvn, ovf_set;
  logic [3:0]       tcnt;
  logic [BW-1:0]    bidx;
  logic [DATA_W-1:0] shreg;
  logic [EW-1:0]    q [DEPTH];
  logic [EW-1:0]    qn [DEPTH];
  logic [EW-1:0]    hold, hn, new_e;
  logic [CW-1:0]    cnt, cn;
  logic             run, last, done, is_brk, brk_end, pe_bit;

  assign run     = rx_on && tick16 && !cmd_rx_off && !cmd_rx_on;
  assign last    = (tcnt == 4'd15);
  assign done    = run && st == S_STOP && last;
  assign is_brk  = done && !rxd && shreg == '0 && (!par_en || !pbit);
  assign brk_end = run && st == S_BRK && rxd && tcnt == 4'd7;
  assign pe_bit  = par_en && ((^shreg ^ pbit) != par_odd) && !is_brk;
  assign new_e   = {is_brk, !rxd, pe_bit, shreg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rx_on <= 1'b0; tcnt <= '0; bidx <= '0; shreg <= '0; pbit <= 1'b0;
    end else if (cmd_rx_off) begin
      rx_on <= 1'b0; st <= S_IDLE;
    end else if (cmd_rx_on) begin
      rx_on <= 1'b1; st <= S_IDLE; tcnt <= '0;
    end else if (run) begin
      case (st)
        S_IDLE: begin
          tcnt <= '0;
          if (!rxd) st <= S_START;
        end
        S_START: begin
          if (tcnt == 4'd7) begin
            tcnt <= '0; bidx <= '0;
            st <= rxd ? S_IDLE : S_DATA;
          end else tcnt <= tcnt + 4'd1;
        end
        S_DATA: begin
          tcnt <= tcnt + 4'd1;
          if (last) begin
            shreg[bidx] <= rxd;
            if (bidx == BW'(DATA_W - 1)) st <= par_en ? S_PAR : S_STOP;
            else bidx <= bidx + 1'b1;
          end
        end
        S_PAR: begin
          tcnt <= tcnt + 4'd1;
          if (last) begin pbit <= rxd; st <= S_STOP; end
        end
        S_STOP: begin
          tcnt <= tcnt + 4'd1;
          if (last) st <= is_brk ? S_BRK : S_IDLE;
        end
        default: begin
          if (!rxd) tcnt <= '0;
          else if (tcnt == 4'd7) begin tcnt <= '0; st <= S_IDLE; end
          else tcnt <= tcnt + 4'd1;
        end
      endcase
    end
  end

  always_comb begin
    qn = q; cn = cnt; hn = hold; hvn = hold_v; ovf_set = 1'b0;
    if (rd && cnt != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) qn[i] = q[i+1];
      qn[DEPTH-1] = '0;
      cn = cnt - 1'b1;
    end
    if (hvn && cn < CW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++) if (CW'(i) == cn) qn[i] = hn;
      cn = cn + 1'b1; hvn = 1'b0;
    end
    if (done) begin
      if (cn < CW'(DEPTH)) begin
        for (int i = 0; i < DEPTH; i++) if (CW'(i) == cn) qn[i] = new_e;
        cn = cn + 1'b1;
      end else begin
        ovf_set = hvn; hn = new_e; hvn = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
      cnt <= '0; hold <= '0; hold_v <= 1'b0; overrun <= 1'b0; brk_chg <= 1'b0;
    end else begin
      q <= qn; cnt <= cn; hold <= hn; hold_v <= hvn;
      overrun <= ovf_set | (overrun & !cmd_clr_err);
      brk_chg <= is_brk | brk_end | (brk_chg & !cmd_clr_brk);
    end
  end

  assign {rx_brk, rx_fe, rx_pe, rx_data} = q[0];
  assign rdy  = (cnt != '0);
  assign full = (cnt == CW'(DEPTH));
endmodule

// File: rtl/uart_rx_stat_chk.sv
`timescale 1ns/1ps
module uart_rx_stat_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd,
  input logic              cmd_clr_err,
  input logic              cmd_clr_brk,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_fe,
  input logic              rx_brk,
  input logic              rdy,
  input logic              full,
  input logic              overrun,
  input logic              brk_chg
);
  assert_rdy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(rd));
  assert_full_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> rdy);
  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !cmd_clr_err |=> overrun);
  assert_ovr_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(full));
  assert_brk_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && rx_brk |-> (rx_data == '0 && rx_fe));
  assert_brkchg_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_chg && !cmd_clr_brk |=> brk_chg);
endmodule

bind uart_rx_stat uart_rx_stat_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .cmd_clr_err(cmd_clr_err),
  .cmd_clr_brk(cmd_clr_brk), .rx_data(rx_data), .rx_fe(rx_fe),
  .rx_brk(rx_brk), .rdy(rdy), .full(full), .overrun(overrun), .brk_chg(brk_chg)
);

// File: tb/test_uart_rx_stat.sv
`timescale 1ns/1ps
module test_uart_rx_stat;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, par_en = 1'b0, par_odd = 1'b0;
  logic cmd_rx_on = 1'b0, cmd_rx_off = 1'b0, cmd_clr_err = 1'b0, cmd_clr_brk = 1'b0, rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_fe, rx_pe, rx_brk, rdy, full, overrun, brk_chg;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  uart_rx_stat i_uart_rx_stat (
    .clk(clk), .rst_n(rst_n), .tick16(1'b1), .rxd(rxd), .par_en(par_en), .par_odd(par_odd),
    .cmd_rx_on(cmd_rx_on), .cmd_rx_off(cmd_rx_off), .cmd_clr_err(cmd_clr_err),
    .cmd_clr_brk(cmd_clr_brk), .rd(rd), .rx_data(rx_data), .rx_fe(rx_fe), .rx_pe(rx_pe),
    .rx_brk(rx_brk), .rdy(rdy), .full(full), .overrun(overrun), .brk_chg(brk_chg));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic use_p, input logic p, input logic stopv);
    @(negedge clk) rxd = 1'b0; idle(15);
    for (int i = 0; i < 8; i++) begin @(negedge clk) rxd = d[i]; idle(15); end
    if (use_p) begin @(negedge clk) rxd = p; idle(15); end
    @(negedge clk) rxd = stopv; idle(15);
    @(negedge clk) rxd = 1'b1;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic t_reset;
    idle(2);
    check("R11 rdy", rdy, 0); check("R11 full", full, 0);
    check("R11 overrun", overrun, 0); check("R11 brk_chg", brk_chg, 0);
    send(8'h42, 0, 0, 1); idle(4);
    check("R11 receiver off", rdy, 0);
  endtask

  task automatic t_basic;
    pulse(cmd_rx_on);
    send(8'hA5, 0, 0, 1); idle(2);
    check("R5 rdy set", rdy, 1); check("R2 data", rx_data, 8'hA5);
    check("R4 fe clear", rx_fe, 0); check("R3 pe off", rx_pe, 0); check("R8 brk clear", rx_brk, 0);
    pulse(rd);
    check("R5 rdy clear", rdy, 0);
  endtask

  task automatic t_glitch;
    @(negedge clk) rxd = 1'b0; idle(3);
    @(negedge clk) rxd = 1'b1; idle(200);
    check("R1 glitch", rdy, 0);
    send(8'h01, 0, 0, 1); idle(2);
    check("R1 after glitch", rx_data, 8'h01);
    pulse(rd);
  endtask

  task automatic t_parity;
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h03, 1, 0, 1); idle(2);
    check("R3 even ok", rx_pe, 0); check("R3 data", rx_data, 8'h03); pulse(rd);
    send(8'h07, 1, 0, 1); idle(2);
    check("R3 even bad", rx_pe, 1); pulse(rd);
    par_odd = 1'b1;
    send(8'h07, 1, 0, 1); idle(2);
    check("R3 odd ok", rx_pe, 0); pulse(rd);
    send(8'h07, 1, 1, 1); idle(2);
    check("R3 odd bad", rx_pe, 1); pulse(rd);
    par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_frame;
    send(8'h3C, 0, 0, 0); idle(40);
    check("R4 fe", rx_fe, 1); check("R4 data", rx_data, 8'h3C); check("R4 not brk", rx_brk, 0);
    pulse(rd);
    check("R4 single entry", rdy, 0);
  endtask

  task automatic t_fifo;
    send(8'h11, 0, 0, 1); send(8'h22, 0, 0, 1); send(8'h33, 0, 0, 1); idle(2);
    check("R6 full", full, 1);
    send(8'h44, 0, 0, 1); idle(2);
    check("R6 still full", full, 1); check("R7 no overrun", overrun, 0);
    pulse(rd);
    check("R6 full after read with held char", full, 1); check("R5 head", rx_data, 8'h22);
    pulse(rd);
    check("R6 full clears", full, 0); check("R5 head 3", rx_data, 8'h33);
    pulse(rd);
    check("R5 head 4", rx_data, 8'h44);
    pulse(rd);
    check("R5 empty", rdy, 0);
  endtask

  task automatic t_overrun;
    send(8'h51, 0, 0, 1); send(8'h52, 0, 0, 1); send(8'h53, 0, 0, 1);
    send(8'h54, 0, 0, 1); send(8'h55, 0, 0, 1); idle(2);
    check("R7 overrun set", overrun, 1);
    check("R7 h1", rx_data, 8'h51); pulse(rd);
    check("R7 h2", rx_data, 8'h52); pulse(rd);
    check("R7 h3", rx_data, 8'h53); pulse(rd);
    check("R7 newest kept", rx_data, 8'h55); pulse(rd);
    check("R7 held one lost", rdy, 0);
    check("R7 sticky", overrun, 1);
    pulse(cmd_clr_err);
    check("R7 cleared", overrun, 0);
  endtask

  task automatic t_break;
    @(negedge clk) rxd = 1'b0; idle(200);
    check("R9 brk start", brk_chg, 1); check("R8 one entry", rdy, 1);
    pulse(cmd_clr_brk);
    check("R9 cleared", brk_chg, 0);
    idle(100);
    @(negedge clk) rxd = 1'b1; idle(4);
    check("R9 not ended yet", brk_chg, 0);
    @(negedge clk) rxd = 1'b0; idle(40);
    @(negedge clk) rxd = 1'b1; idle(20);
    check("R9 brk end", brk_chg, 1);
    check("R8 brk flag", rx_brk, 1); check("R8 data zero", rx_data, 0);
    check("R8 fe", rx_fe, 1); check("R8 pe", rx_pe, 0);
    pulse(rd);
    check("R8 single slot", rdy, 0);
    pulse(cmd_clr_brk);
    send(8'h5A, 0, 0, 1); idle(2);
    check("R8 reception resumes", rx_data, 8'h5A); check("R8 resumed brk", rx_brk, 0);
    pulse(rd);
  endtask

  task automatic t_disable;
    send(8'h99, 0, 0, 1); idle(2);
    @(negedge clk) rxd = 1'b0; idle(40);
    pulse(cmd_rx_off);
    @(negedge clk) rxd = 1'b1; idle(200);
    check("R10 rdy kept", rdy, 1); check("R10 head kept", rx_data, 8'h99);
    check("R10 overrun kept", overrun, 0);
    send(8'h77, 0, 0, 1); idle(4);
    pulse(rd);
    check("R10 off ignores char", rdy, 0);
    pulse(cmd_rx_on);
    send(8'h81, 0, 0, 1); idle(2);
    check("R10 re-enabled", rx_data, 8'h81);
    pulse(rd);
  endtask

  initial begin
    idle(3); rst_n = 1'b1;
    t_reset; t_basic; t_glitch; t_parity; t_frame; t_fifo; t_overrun; t_break; t_disable;
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule